// File: doc/BRIEF.md
# Code-Protect Aware Program Memory Checksum Engine

This block walks a word-wide memory through a synchronous read port and folds its contents into a 16-bit device checksum. A single start pulse launches one pass. The engine captures two things at that pulse: whether code protection applies, and the highest user address, which holds an oscillator trim word. From these it decides which words enter the sum. With protection off, every user word below the trim word is added. With protection on, only the small always-readable window at the bottom of memory is added, and the identification nibbles are folded in as one packed term. In both cases the configuration word is added after masking.

Reads go out one per clock. Each returned word is accumulated one cycle after its address was presented. When the last contribution has been added, a one-cycle done pulse marks the checksum output as valid. The output then keeps its value until the next accepted start. File parsing and driving a real device's serial pins belong to the surrounding system.

Top module: `cp_checksum_unit`

## Requirements
- R1: With protection off, the result is the sum of words at addresses 0 through top_addr_i-1 plus the masked configuration word; the word at top_addr_i is not read and not added.
- R2: With protection on, the result is the sum of words at addresses 0x000 through 0x03F, plus the masked configuration word, plus the packed identification value.
- R3: The configuration word is read from address 0xFFF, and only its bits 4:0 (AND with 0x01F) enter the sum.
- R4: The four identification words are read at top_addr_i+1 up to top_addr_i+4. Only bits 3:0 of each are used. The packed value places the nibble from top_addr_i+1 in bits 15:12 and the nibble from top_addr_i+4 in bits 3:0, so IDs 0x12, 0x37, 0x4 and 0x26 pack to 0x2746.
- R5: The sum is kept modulo 2^16; a blank 512-word memory (all 0xFFF, top_addr_i = 0x1FF, configuration 0xFFF) with protection off yields 0xEE20.
- R6: mem_rd_o is high with a valid mem_addr_o for exactly one cycle per word. The data is taken from mem_data_i in the following cycle. The reads cover the user words in ascending order, then the configuration word, then the ID words. done_o rises N+2 clocks after the start edge, where N is the number of words read.
- R7: done_o is high for exactly one cycle, and sum_o is valid in that cycle. sum_o then holds its value until the next accepted start.
- R8: A start pulse that arrives while a pass is running is ignored; the running pass completes with its own result and no extra pass follows.
- R9: After reset, done_o, mem_rd_o and sum_o are all 0.
- R10: cp_on_i and top_addr_i are sampled only at the accepted start; changes during a pass do not affect its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a pass |
| cp_on_i | input | 1 | 1 selects the protected checksum rule |
| top_addr_i | input | 12 | Highest user address (trim word location) |
| mem_rd_o | output | 1 | Read strobe to the memory |
| mem_addr_o | output | 12 | Read address |
| mem_data_i | input | 12 | Read data, valid one cycle after the strobe |
| sum_o | output | 16 | Checksum result |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
Several properties are checked by assertions on every cycle. Inside the user range, consecutive read addresses step by one. The ID reads begin just above the captured top address. The masked configuration term never carries bits above the mask. done_o never lasts two cycles, and sum_o stays still while the engine is idle. A read burst only ever starts from an accepted start. Other properties can only be shown by the bench's scenarios. These are the arithmetic value of the result under each protection rule, the wrap to 16 bits, the exclusion of the trim word, the nibble order of the packed IDs, the exact read count and latency, and immunity to a second start or to input changes during a pass.

// File: rtl/cksum_pkg.sv
package cksum_pkg;

   // Kind of word returned by the memory, carried alongside each read.
   typedef enum logic [1:0] {
      ITEM_PROG = 2'd0,
      ITEM_CFG  = 2'd1,
      ITEM_ID   = 2'd2
   } item_kind_e;

   // Read-issue phases of the address sequencer.
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_PROG = 2'd1,
      SEQ_CFG  = 2'd2,
      SEQ_ID   = 2'd3
   } seq_state_e;

endpackage

// File: rtl/cksum_addr_seq.sv
module cksum_addr_seq
   import cksum_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned PROT_LAST = 'h03F,
   parameter int unsigned CFG_ADDR  = 'hFFF,
   parameter int unsigned ID_COUNT  = 4,
   localparam int unsigned IDX_W    = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              cp_i,
   input  logic [ADDR_W-1:0] top_i,
   output logic              rd_o,
   output logic [ADDR_W-1:0] addr_o,
   output item_kind_e        kind_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              last_o
);

   localparam logic [ADDR_W-1:0] PROT_A  = ADDR_W'(PROT_LAST);
   localparam logic [ADDR_W-1:0] CFG_A   = ADDR_W'(CFG_ADDR);
   localparam logic [IDX_W-1:0]  ID_LAST = IDX_W'(ID_COUNT - 1);

   seq_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] end_q;
   logic [ADDR_W-1:0] top_q;
   logic [IDX_W-1:0]  idx_q;
   logic              cp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         addr_q  <= '0;
         end_q   <= '0;
         top_q   <= '0;
         idx_q   <= '0;
         cp_q    <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (go_i) begin
                  cp_q    <= cp_i;
                  top_q   <= top_i;
                  end_q   <= cp_i ? PROT_A : (top_i - 1'b1);
                  addr_q  <= '0;
                  idx_q   <= '0;
                  state_q <= SEQ_PROG;
               end
            end
            SEQ_PROG: begin
               if (addr_q == end_q) begin
                  addr_q  <= CFG_A;
                  state_q <= SEQ_CFG;
               end else begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            SEQ_CFG: begin
               if (cp_q) begin
                  addr_q  <= top_q + 1'b1;
                  idx_q   <= '0;
                  state_q <= SEQ_ID;
               end else begin
                  state_q <= SEQ_IDLE;
               end
            end
            SEQ_ID: begin
               if (idx_q == ID_LAST) begin
                  state_q <= SEQ_IDLE;
               end else begin
                  addr_q <= addr_q + 1'b1;
                  idx_q  <= idx_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_o   = (state_q != SEQ_IDLE);
      addr_o = addr_q;
      idx_o  = idx_q;
      case (state_q)
         SEQ_CFG: kind_o = ITEM_CFG;
         SEQ_ID:  kind_o = ITEM_ID;
         default: kind_o = ITEM_PROG;
      endcase
      last_o = ((state_q == SEQ_CFG) && !cp_q) ||
               ((state_q == SEQ_ID) && (idx_q == ID_LAST));
   end

   // R6: user-range reads walk upward one word per cycle.
   p_addr_step_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == SEQ_PROG) && ($past(state_q) == SEQ_PROG))
         |-> (addr_q == $past(addr_q) + 1'b1));

   // R4: the first ID read sits directly above the captured top address.
   p_id_base_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == SEQ_ID) && ($past(state_q) == SEQ_CFG))
         |-> (addr_q == top_q + 1'b1));

endmodule

// File: rtl/cksum_term.sv
module cksum_term
   import cksum_pkg::*;
#(
   parameter int unsigned DATA_W       = 12,
   parameter int unsigned SUM_W        = 16,
   parameter int unsigned NIB_W        = 4,
   parameter int unsigned ID_COUNT     = 4,
   parameter int unsigned CFG_MASK     = 'h01F,
   parameter bit          ID_MSB_FIRST = 1'b1,
   localparam int unsigned IDX_W       = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1
) (
   input  logic [DATA_W-1:0] data_i,
   input  item_kind_e        kind_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [SUM_W-1:0]  term_o
);

   localparam logic [SUM_W-1:0] MASK_V = SUM_W'(CFG_MASK);

   logic [IDX_W-1:0] pos;

   generate
      if (ID_MSB_FIRST) begin : g_msb_first
         assign pos = IDX_W'(ID_COUNT - 1) - idx_i;
      end else begin : g_lsb_first
         assign pos = idx_i;
      end
   endgenerate

   always_comb begin
      case (kind_i)
         ITEM_CFG: term_o = SUM_W'(data_i) & MASK_V;
         ITEM_ID:  term_o = SUM_W'(data_i[NIB_W-1:0]) << (int'(pos) * NIB_W);
         default:  term_o = SUM_W'(data_i);
      endcase
   end

endmodule

// File: rtl/cksum_accum.sv
module cksum_accum #(
   parameter int unsigned SUM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             add_i,
   input  logic             last_i,
   input  logic [SUM_W-1:0] term_i,
   output logic [SUM_W-1:0] sum_o,
   output logic             done_o
);

   logic [SUM_W-1:0] sum_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= add_i && last_i;
         if (clear_i) begin
            sum_q <= '0;
         end else if (add_i) begin
            sum_q <= sum_q + term_i;
         end
      end
   end

   assign sum_o  = sum_q;
   assign done_o = done_q;

   // R7: the result-valid flag never stretches over two cycles.
   p_done_single_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/cp_checksum_unit.sv
module cp_checksum_unit
   import cksum_pkg::*;
#(
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned DATA_W       = 12,
   parameter int unsigned SUM_W        = 16,
   parameter int unsigned NIB_W        = 4,
   parameter int unsigned ID_COUNT     = 4,
   parameter int unsigned PROT_LAST    = 'h03F,
   parameter int unsigned CFG_ADDR     = 'hFFF,
   parameter int unsigned CFG_MASK     = 'h01F,
   parameter bit          ID_MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cp_on_i,
   input  logic [ADDR_W-1:0] top_addr_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [SUM_W-1:0]  sum_o,
   output logic              done_o
);

   localparam int unsigned IDX_W = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1;

   generate
      if (SUM_W < DATA_W) begin : g_bad_sum_w
         $error("SUM_W must be at least DATA_W");
      end
      if (SUM_W < ID_COUNT * NIB_W) begin : g_bad_pack
         $error("packed ID value does not fit SUM_W");
      end
      if (NIB_W > DATA_W) begin : g_bad_nib
         $error("NIB_W exceeds DATA_W");
      end
      if (ID_COUNT < 2) begin : g_bad_ids
         $error("ID_COUNT must be at least 2");
      end
      if (PROT_LAST >= (1 << ADDR_W) || CFG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("fixed addresses exceed ADDR_W");
      end
   endgenerate

   logic              busy_q;
   logic              go;
   logic              seq_rd;
   logic [ADDR_W-1:0] seq_addr;
   item_kind_e        seq_kind;
   logic [IDX_W-1:0]  seq_idx;
   logic              seq_last;

   logic              tag_valid_q;
   item_kind_e        tag_kind_q;
   logic [IDX_W-1:0]  tag_idx_q;
   logic              tag_last_q;
   logic [SUM_W-1:0]  term;

   assign go = start_i && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (go) begin
         busy_q <= 1'b1;
      end else if (tag_valid_q && tag_last_q) begin
         busy_q <= 1'b0;
      end
   end

   cksum_addr_seq #(
      .ADDR_W    (ADDR_W),
      .PROT_LAST (PROT_LAST),
      .CFG_ADDR  (CFG_ADDR),
      .ID_COUNT  (ID_COUNT)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (go),
      .cp_i   (cp_on_i),
      .top_i  (top_addr_i),
      .rd_o   (seq_rd),
      .addr_o (seq_addr),
      .kind_o (seq_kind),
      .idx_o  (seq_idx),
      .last_o (seq_last)
   );

   // Tag travels with the read so it meets its data one cycle later.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_valid_q <= 1'b0;
         tag_kind_q  <= ITEM_PROG;
         tag_idx_q   <= '0;
         tag_last_q  <= 1'b0;
      end else begin
         tag_valid_q <= seq_rd;
         tag_kind_q  <= seq_kind;
         tag_idx_q   <= seq_idx;
         tag_last_q  <= seq_rd && seq_last;
      end
   end

   cksum_term #(
      .DATA_W       (DATA_W),
      .SUM_W        (SUM_W),
      .NIB_W        (NIB_W),
      .ID_COUNT     (ID_COUNT),
      .CFG_MASK     (CFG_MASK),
      .ID_MSB_FIRST (ID_MSB_FIRST)
   ) u_term (
      .data_i (mem_data_i),
      .kind_i (tag_kind_q),
      .idx_i  (tag_idx_q),
      .term_o (term)
   );

   cksum_accum #(
      .SUM_W (SUM_W)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (go),
      .add_i   (tag_valid_q),
      .last_i  (tag_last_q),
      .term_i  (term),
      .sum_o   (sum_o),
      .done_o  (done_o)
   );

   assign mem_rd_o   = seq_rd;
   assign mem_addr_o = seq_addr;

   // R9: no memory traffic while no pass is running.
   p_idle_no_read_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !mem_rd_o);

   // R8: a read burst only begins after a start taken while idle.
   p_start_only_idle_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd_o) |-> $past(start_i && !busy_q));

   // R3: the configuration contribution carries no bits above the mask.
   p_cfg_masked_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (tag_valid_q && (tag_kind_q == ITEM_CFG))
         |-> ((term & ~SUM_W'(CFG_MASK)) == '0));

   // R7: the result stays put between passes.
   p_sum_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start_i) |=> $stable(sum_o));

endmodule

// File: tb/cp_checksum_unit_bench.sv
module cp_checksum_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cp_on_i = 1'b0;
   logic [11:0] top_addr_i = 12'h1FF;
   logic        mem_rd_o;
   logic [11:0] mem_addr_o;
   logic [11:0] mem_data_i = '0;
   logic [15:0] sum_o;
   logic        done_o;

   always #2 clk = ~clk;   // 250 MHz

   cp_checksum_unit u_cp_checksum_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .cp_on_i    (cp_on_i),
      .top_addr_i (top_addr_i),
      .mem_rd_o   (mem_rd_o),
      .mem_addr_o (mem_addr_o),
      .mem_data_i (mem_data_i),
      .sum_o      (sum_o),
      .done_o     (done_o)
   );

   // Synchronous memory model: data follows the strobe by one edge.
   logic [11:0] mem [0:4095];
   always @(posedge clk) if (mem_rd_o) mem_data_i <= mem[mem_addr_o];

   int checks = 0;
   int errors = 0;
   int pcount = 0;
   int rd_cnt = 0;
   int dones  = 0;
   int t_start = 0;
   bit prev_done = 1'b0;
   string cur_tag = "";
   int unsigned sb_q[$];
   int lat_q[$];

   always @(posedge clk) pcount <= pcount + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Monitor / scoreboard.
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_o) rd_cnt++;
         if (done_o) begin
            chk(!prev_done, "R7 done width", 1, 0);
            if (sb_q.size() == 0) begin
               chk(1'b0, "R8 unexpected done", 1, 0);
            end else begin
               int unsigned e;
               int l;
               e = sb_q.pop_front();
               l = lat_q.pop_front();
               chk(sum_o == e[15:0], cur_tag, int'(sum_o), int'(e));
               chk((pcount - t_start) == l, "R6 latency", pcount - t_start, l);
            end
            dones++;
         end
         prev_done = done_o;
      end
   end

   function automatic int unsigned calc(input bit cp, input int top);
      int unsigned s = 0;
      int hi = cp ? 'h3F : top - 1;
      for (int a = 0; a <= hi; a++) s += mem[a];
      s += mem[12'hFFF] & 'h1F;
      if (cp) for (int k = 0; k < 4; k++) s += (mem[top + 1 + k] & 'hF) << (4 * (3 - k));
      return s & 'hFFFF;
   endfunction

   // inj: 0 none, 1 second start mid-pass (R8), 2 input change mid-pass (R10)
   task automatic run_case(input bit cp, input int top, input int force_exp,
                           input int inj, input string tag);
      int unsigned e;
      int n;
      int d0;
      e = (force_exp >= 0) ? int'(force_exp) : calc(cp, top);
      n = (cp ? 64 : top) + 1 + (cp ? 4 : 0);
      cur_tag = tag;
      sb_q.push_back(e);
      lat_q.push_back(n + 2);
      rd_cnt = 0;
      d0 = dones;
      @(negedge clk);
      cp_on_i = cp; top_addr_i = 12'(top); start_i = 1'b1; t_start = pcount;
      @(negedge clk);
      start_i = 1'b0;
      if (inj != 0) begin
         repeat (8) @(negedge clk);
         cp_on_i = ~cp;
         top_addr_i = 12'(top) ^ 12'h100;
         if (inj == 1) start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (dones == d0) @(negedge clk);
      chk(rd_cnt == n, "R6 read count", rd_cnt, n);
      repeat (3) @(negedge clk);
      chk(sum_o == e[15:0], "R7 hold", int'(sum_o), int'(e));
      chk(dones == d0 + 1, "R8 single pass", dones, d0 + 1);
   endtask

   task automatic fill(input int seed);
      for (int a = 0; a < 4096; a++) mem[a] = 12'((a * 37 + seed * 113) ^ (a >> 3));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int a = 0; a < 4096; a++) mem[a] = 12'hFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_o == 1'b0, "R9 done", int'(done_o), 0);
      chk(mem_rd_o == 1'b0, "R9 rd", int'(mem_rd_o), 0);
      chk(sum_o == 16'h0, "R9 sum", int'(sum_o), 0);

      // R5 / R1: blank part, literal value
      run_case(1'b0, 'h1FF, 'hEE20, 0, "R5 blank off");

      // R4 / R2: packed IDs 0x12,0x37,0x4,0x26 -> 0x2746; cfg 0xFF7 -> 0x17
      for (int a = 0; a < 4096; a++) mem[a] = 12'h000;
      mem['h200] = 12'h012; mem['h201] = 12'h037;
      mem['h202] = 12'h004; mem['h203] = 12'h026;
      mem['hFFF] = 12'hFF7;
      run_case(1'b1, 'h1FF, 'h275D, 0, "R4 packed ids");

      // R1 / R3: pattern, bigger part, trim word made distinctive
      fill(3);
      mem['h3FF] = 12'hABC; mem['hFFF] = 12'hABC;
      run_case(1'b0, 'h3FF, -1, 0, "R1 off pattern");

      // R2: protected, pattern
      fill(7);
      run_case(1'b1, 'h1FF, -1, 0, "R2 on pattern");
      run_case(1'b1, 'h3FF, -1, 0, "R2 on large");

      // R3: configuration masked
      fill(11);
      mem['hFFF] = 12'hFE0;
      run_case(1'b0, 'h0FF, -1, 0, "R3 cfg mask");

      // R8: second start mid-pass ignored
      fill(5);
      run_case(1'b0, 'h1FF, -1, 1, "R8 busy start");

      // R10: inputs change mid-pass
      run_case(1'b1, 'h1FF, -1, 2, "R10 input change");

      repeat (4) @(negedge clk);
      chk(sb_q.size() == 0, "R8 leftover", sb_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule